// File: doc/BRIEF.md
# Dual Interval Timer with Bus-Cycle Watchdog

This block pairs two reloading 24-bit interval timers with an 8-bit watchdog that polices local bus cycles. Each timer counts down from a programmed reload value. When it reaches zero it produces a one-clock terminal-count event and reloads, so its events repeat at a fixed fraction of the clock rate. Timer 0 drives the interrupt line, which can be set to a one-clock pulse or to a level that software acknowledges. Timer 1 can take over a shared output pin that otherwise carries the refresh-in-progress indication from the memory sequencer.

The watchdog arms whenever a bus cycle starts and loads a programmed timeout. If the cycle's ready arrives in time, the watchdog stands down quietly. If the count runs out first, it answers the cycle with a one-clock bus error so that an access to empty address space cannot hang the bus. Configuration is written through a plain register-write strobe that only takes effect in supervisor mode. The block carries no streaming data, so every pin is a plain control or status signal and none of them has back-pressure.

Top module: `tbw_unit`

## Requirements
- R1: After reset `irq` and `bus_err` are low, both timers are stopped, and `rfs_aux` follows `refresh_in`.
- R2: A supervisor write places `reg_wdata[23:0]` in the timer 0 reload register at address 0 and in the timer 1 reload register at address 1. A reload value written while a timer runs takes effect from its next terminal count.
- R3: With timer 0 enabled (control bit 0), interrupts enabled (control bit 2) and pulse mode selected (control bit 3 = 0), `irq` is high for exactly one clock. Successive `irq` pulses are reload+1 clocks apart, for a reload of 1 or more.
- R4: With control bit 2 clear, timer 0 terminal counts never raise `irq`.
- R5: In level mode (control bit 3 = 1), a terminal count with interrupts enabled sets `irq`, and `irq` stays high even after the timer stops. A supervisor write to address 3 with bit 0 set clears it. When a terminal count and a clear fall in the same cycle, the terminal count wins.
- R6: With control bit 4 = 0, `rfs_aux` equals `refresh_in`. With control bit 4 = 1, `rfs_aux` shows timer 1's one-clock terminal-count pulses, every reload+1 clocks, while timer 1 runs (control bit 1).
- R7: A `bus_start` sampled at a clock edge loads the timeout held at address 4 (bits 7:0), called T. If `bus_rdy` is not sampled within the next T+1 edges, `bus_err` is high for exactly the one clock after the (T+1)th edge. A `bus_rdy` that arrives after the error is ignored.
- R8: A `bus_rdy` sampled on any of the T+1 edges after the start, the (T+1)th included, ends the watch with no error.
- R9: A write with `reg_sup` low changes no register and does not clear `irq`.
- R10: A disabled timer produces no terminal count and holds its reload value. On enable, its first terminal count comes reload+1 clocks after the enabling write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sup | input | 1 | Supervisor mode indication for the write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| bus_start | input | 1 | Bus cycle begins (one clock) |
| bus_rdy | input | 1 | Ready returned for the current bus cycle |
| refresh_in | input | 1 | Refresh-in-progress indication from the memory sequencer |
| irq | output | 1 | Timer 0 interrupt |
| rfs_aux | output | 1 | Shared pin: refresh indication or timer 1 event |
| bus_err | output | 1 | Bus-cycle timeout error |

## Verification
The watchdog's expiry and the arrival of ready can land on the same clock edge. The bench provokes this by starting a cycle with timeout T and returning ready exactly on the (T+1)th edge, which is the edge on which the error would otherwise be raised. The scoreboard is given no expected error for that cycle, and any `bus_err` it sees counts as a failure. Neighbouring cases on either side, with ready earlier and with ready one edge too late, give the expected outcome on each side of that boundary.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int N_TMR  = 2;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 5;

  localparam logic [ADDR_W-1:0] ADR_RLD_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR      = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TMO      = 3'd4;

  typedef struct packed {
    logic aux_sel;
    logic irq_lvl;
    logic irq_en;
    logic t1_en;
    logic t0_en;
  } ctrl_t;
endpackage

// File: rtl/tbw_regs.sv
module tbw_regs
  import tbw_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int BW_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_sup,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [TMR_W-1:0]            reg_wdata,
  output logic [N_TMR-1:0][TMR_W-1:0] reload_o,
  output ctrl_t                       ctrl_o,
  output logic [BW_W-1:0]             tmo_o,
  output logic                        clr_o
);
  logic wr_ok;
  assign wr_ok = reg_wr && reg_sup;
  assign clr_o = wr_ok && (reg_addr == ADR_CLR) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_o <= '0;
      ctrl_o   <= '0;
      tmo_o    <= '1;
    end else if (wr_ok) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (reg_addr == ADR_RLD_BASE + ADDR_W'(i)) reload_o[i] <= reg_wdata;
      end
      if (reg_addr == ADR_CTRL) ctrl_o <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_addr == ADR_TMO)  tmo_o  <= reg_wdata[BW_W-1:0];
    end
  end
endmodule

// File: rtl/tbw_timer.sv
module tbw_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         tc
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tc  <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (!en) begin
        cnt <= reload;
      end else if (cnt == '0) begin
        cnt <= reload;
        tc  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbw_watch.sv
module tbw_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         rdy,
  input  logic [W-1:0] tmo,
  output logic         err
);
  logic         busy;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= tmo;
      end else if (busy) begin
        if (rdy) begin
          busy <= 1'b0;
        end else if (cnt == '0) begin
          busy <= 1'b0;
          err  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tbw_unit.sv
module tbw_unit
  import tbw_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int BW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sup,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [TMR_W-1:0]  reg_wdata,
  input  logic              bus_start,
  input  logic              bus_rdy,
  input  logic              refresh_in,
  output logic              irq,
  output logic              rfs_aux,
  output logic              bus_err
);
  logic [N_TMR-1:0][TMR_W-1:0] reload_q;
  ctrl_t                       ctrl_q;
  logic [BW_W-1:0]             tmo_q;
  logic                        clr;
  logic [N_TMR-1:0]            tmr_en;
  logic [N_TMR-1:0]            tmr_tc;
  logic                        lvl_q;

  tbw_regs #(.TMR_W(TMR_W), .BW_W(BW_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sup  (reg_sup),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reload_o (reload_q),
    .ctrl_o   (ctrl_q),
    .tmo_o    (tmo_q),
    .clr_o    (clr)
  );

  assign tmr_en = {ctrl_q.t1_en, ctrl_q.t0_en};

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tbw_timer #(.W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en[g]),
      .reload(reload_q[g]),
      .tc    (tmr_tc[g])
    );
  end

  // level latch: a new terminal count outranks an acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lvl_q <= 1'b0;
    else if (!ctrl_q.irq_lvl)               lvl_q <= 1'b0;
    else if (tmr_tc[0] && ctrl_q.irq_en)    lvl_q <= 1'b1;
    else if (clr)                           lvl_q <= 1'b0;
  end

  assign irq     = ctrl_q.irq_lvl ? lvl_q : (tmr_tc[0] & ctrl_q.irq_en);
  assign rfs_aux = ctrl_q.aux_sel ? tmr_tc[1] : refresh_in;

  tbw_watch #(.W(BW_W)) u_watch (
    .clk  (clk),
    .rst_n(rst_n),
    .start(bus_start),
    .rdy  (bus_rdy),
    .tmo  (tmo_q),
    .err  (bus_err)
  );
endmodule

// File: rtl/tbw_unit_chk.sv
module tbw_unit_chk
  import tbw_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              bus_err,
  input logic              bus_rdy,
  input logic              reg_wr,
  input logic              reg_sup,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              clr_bit,
  input ctrl_t             ctrl,
  input logic [TMR_W-1:0]  reload0,
  input logic              tc0
);
  logic ack;
  assign ack = reg_wr && reg_sup && (reg_addr == ADR_CLR) && clr_bit;

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err); // R7
  AST_RDY_BLOCKS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> !bus_err); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl.irq_lvl && $past(reload0) != '0) |=> (!irq || ctrl.irq_lvl)); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ctrl.irq_lvl && !ack) |=> (irq || !ctrl.irq_lvl)); // R5
  AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sup) |=> ($stable(ctrl) && $stable(reload0))); // R9
  AST_DISABLED_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.t0_en |=> !tc0); // R10
endmodule

bind tbw_unit tbw_unit_chk #(.TMR_W(TMR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .bus_err (bus_err),
  .bus_rdy (bus_rdy),
  .reg_wr  (reg_wr),
  .reg_sup (reg_sup),
  .reg_addr(reg_addr),
  .clr_bit (reg_wdata[0]),
  .ctrl    (ctrl_q),
  .reload0 (reload_q[0]),
  .tc0     (tmr_tc[0])
);

// File: tb/tbw_unit_tb.sv
module tbw_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sup = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        bus_start = 1'b0;
  logic        bus_rdy = 1'b0;
  logic        refresh_in = 1'b1;
  logic        irq, rfs_aux, bus_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int err_cnt = 0;
  int exp_q[$];

  tbw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sup(reg_sup),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bus_start(bus_start),
    .bus_rdy(bus_rdy), .refresh_in(refresh_in), .irq(irq),
    .rfs_aux(rfs_aux), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops expected error cycles and compares against bus_err
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (bus_err) err_cnt++;
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        void'(exp_q.pop_front());
        check(bus_err == 1'b1, "R7 error cycle", int'(bus_err), 1);
      end else if (bus_err) begin
        check(1'b0, "R8 unexpected error", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic wr(input logic [2:0] a, input logic [23:0] d, input bit sup);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_sup = sup;
    @(negedge clk);
    reg_wr = 1'b0; reg_sup = 1'b0;
  endtask

  function automatic bit smp(input bit use_aux);
    return use_aux ? rfs_aux : irq;
  endfunction

  task automatic measure(input bit use_aux, output int per, output int wid);
    bit prev, cur, seen_fall;
    int k;
    per = -1; wid = -1;
    prev = 1'b1;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      cur = smp(use_aux);
      if (cur && !prev) break;
      prev = cur;
    end
    k = 0; seen_fall = 1'b0; prev = 1'b1;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      k++;
      cur = smp(use_aux);
      if (!cur && !seen_fall) begin seen_fall = 1'b1; wid = k; end
      if (cur && !prev) begin per = k; break; end
      prev = cur;
    end
  endtask

  task automatic count_irq(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) highs++;
    end
  endtask

  // driver: pushes the expected error cycle, then plays the bus cycle
  task automatic bus_cycle(input int tmo, input int rdy_edge, input bit expect_err,
                           input string req);
    int c, e0;
    @(negedge clk);
    e0 = err_cnt;
    bus_start = 1'b1;
    c = cyc;
    if (expect_err) exp_q.push_back(c + tmo + 2);
    @(negedge clk);
    bus_start = 1'b0;
    if (rdy_edge > 0) begin
      repeat (rdy_edge - 1) @(negedge clk);
      bus_rdy = 1'b1;
      @(negedge clk);
      bus_rdy = 1'b0;
    end
    repeat (tmo + 6) @(negedge clk);
    check(err_cnt - e0 == int'(expect_err), req, err_cnt - e0, int'(expect_err));
  endtask

  initial begin
    int per, wid, highs, first;
    bit found;
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R1 irq at reset", int'(irq), 0);
    check(bus_err == 1'b0, "R1 bus_err at reset", int'(bus_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rfs_aux == 1'b1, "R1 pin follows refresh", int'(rfs_aux), 1);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

    // R3: pulse mode, reload 5 -> period 6, width 1
    wr(3'd0, 24'd5, 1'b1);
    wr(3'd2, 24'b00101, 1'b1);
    measure(1'b0, per, wid);
    check(per == 6, "R3 irq period", per, 6);
    check(wid == 1, "R3 irq width", wid, 1);

    // R2: new reload written while running
    wr(3'd0, 24'd9, 1'b1);
    measure(1'b0, per, wid);
    check(per == 10, "R2 reload at address 0", per, 10);

    // R9: user-mode write of the reload is ignored
    wr(3'd0, 24'd2, 1'b0);
    measure(1'b0, per, wid);
    check(per == 10, "R9 user reload write", per, 10);

    // R4: interrupts disabled, timer running
    wr(3'd2, 24'b00001, 1'b1);
    count_irq(25, highs);
    check(highs == 0, "R4 irq gated", highs, 0);

    // R10: timer stopped, irq enabled
    wr(3'd2, 24'b00100, 1'b1);
    count_irq(25, highs);
    check(highs == 0, "R10 stopped timer silent", highs, 0);
    wr(3'd2, 24'b00101, 1'b1);
    first = -1;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (irq) begin first = j; break; end
    end
    check(first == 10, "R10 first event after enable", first, 10);

    // R5: level mode
    wr(3'd2, 24'b01101, 1'b1);
    found = 1'b0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (irq) begin found = 1'b1; break; end
    end
    check(found, "R5 level set", int'(found), 1);
    wr(3'd2, 24'b01100, 1'b1);
    repeat (15) @(negedge clk);
    check(irq == 1'b1, "R5 level held", int'(irq), 1);
    wr(3'd3, 24'd1, 1'b0);
    check(irq == 1'b1, "R9 user clear ignored", int'(irq), 1);
    wr(3'd3, 24'd1, 1'b1);
    check(irq == 1'b0, "R5 level cleared", int'(irq), 0);

    // R6: shared pin
    wr(3'd2, 24'd0, 1'b1);
    @(negedge clk); refresh_in = 1'b0;
    @(negedge clk);
    check(rfs_aux == 1'b0, "R6 pin follows refresh low", int'(rfs_aux), 0);
    refresh_in = 1'b1;
    @(negedge clk);
    check(rfs_aux == 1'b1, "R6 pin follows refresh high", int'(rfs_aux), 1);
    wr(3'd1, 24'd3, 1'b1);
    wr(3'd2, 24'b10010, 1'b1);
    measure(1'b1, per, wid);
    check(per == 4, "R6 aux period", per, 4);
    check(wid == 1, "R6 aux width", wid, 1);
    wr(3'd2, 24'd0, 1'b1);

    // bus watch
    wr(3'd4, 24'd4, 1'b1);
    bus_cycle(4, 0, 1'b1, "R7 timeout 4");
    bus_cycle(4, 6, 1'b1, "R7 late ready ignored");
    wr(3'd4, 24'd0, 1'b1);
    bus_cycle(0, 0, 1'b1, "R7 timeout 0");
    wr(3'd4, 24'd4, 1'b1);
    bus_cycle(4, 5, 1'b0, "R8 ready on expiry edge");
    bus_cycle(4, 2, 1'b0, "R8 early ready");
    wr(3'd4, 24'd1, 1'b0);
    bus_cycle(4, 0, 1'b1, "R9 user timeout write");

    check(exp_q.size() == 0, "R7 all errors seen", exp_q.size(), 0);
    finish_run();
  end
endmodule